// File: doc/BRIEF.md
# System Sleep and Reset Controller

This block is a small register slave on a simple I/O bus. It holds three registers. The first is a byte-wide reset control register. The second is a 16-bit power-management control register that carries a sleep-type field, a sleep-enable trigger and the SCI enable flag. The third is a write-only byte command port that turns power-management mode on or off.

The block turns register writes into single-cycle requests to the system. A reset request fires when bit 2 of the reset register rises. A soft-off request fires when a control write sets the sleep trigger while the stored sleep type is 5. Two levels are also driven: the SCI enable flag, and an arm signal for the power-button event source. Only the command port can move those two levels.

Each bus access is a single-cycle strobe. Read data, the error flag and the request pulses all appear in the cycle after the strobe. The size field is encoded as 0 for one byte, 1 for two bytes, 2 for four bytes and 3 reserved.

Top module: `slp_rst_ctl`

## Requirements
- R1: A 1-byte read at address RST_ADDR (default 0x0CF9) returns, in bits 7:0, the last byte written there with a 1-byte write; bits 15:8 read as zero.
- R2: `rstReq` is high for exactly one cycle, in the cycle after a 1-byte write to RST_ADDR whose bit 2 is 1 while the stored bit 2 is 0. A write with bit 2 set while the stored bit 2 is already 1 gives no pulse.
- R3: Bit 1 of the reset register (0 soft, 1 hard) has no effect on the request: both values produce the same single `rstReq` pulse.
- R4: A 2-byte write to CTL_ADDR stores written bits 12:2. Bits 15, 14, 13 and 1 are stored as zero, so the sleep-enable trigger at bit 13 always reads back as 0.
- R5: Bit 0 of the control register (SCI enable, also driven on `sciEn`) keeps its value across any control-register write, whatever value is written.
- R6: `pwrOffReq` pulses for one cycle, in the cycle after a 2-byte control write with bit 13 set and written bits 12:10 equal to 5. It does not pulse for any other sleep type, or when bit 13 is clear.
- R7: A 1-byte write of CMD_ENABLE to CMD_ADDR sets `sciEn` and `pwrBtnArm`. A write of CMD_DISABLE clears both. Any other byte changes neither. A 1-byte read of CMD_ADDR returns 0.
- R8: An access to RST_ADDR or CMD_ADDR whose size is not one byte, or to CTL_ADDR whose size is not two bytes, raises `busErr` for one cycle in the cycle after the strobe. It changes no register and returns 0 on `busRdata`.
- R9: After reset, every register, `sciEn`, `pwrBtnArm`, both request pulses, `busErr` and `busRdata` are zero.
- R10: `busRdata` carries the read value only in the cycle after a read strobe and is zero in every other cycle. Accesses to unmapped addresses return 0 without an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Access address |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access (takes precedence over read) |
| busSize | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid the cycle after a read |
| busErr | output | 1 | Size error flag, the cycle after the access |
| rstReq | output | 1 | One-cycle system reset request |
| pwrOffReq | output | 1 | One-cycle soft-off request |
| sciEn | output | 1 | SCI enable level |
| pwrBtnArm | output | 1 | Arms the power-button event source |

## Verification
The bench builds the block with the control register moved to 0x1004 and the command codes set to 0xF0 for enable and 0x0F for disable, rather than the defaults. A decoder that ignored its parameters would then miss every control and command access. With these values, the default enable code 0xA0 becomes an "other value" that must be ignored. The reset register keeps 0x0CF9, which tests the fixed address decode alongside the parameterised ones. Sleep types on either side of 5, repeated reset writes with bit 2 already set, and wrong-size accesses to every register are compared against the cycle model on every clock.

// File: rtl/slp_rst_pkg.sv
package slp_rst_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  localparam int CTL_W       = 16;
  localparam int SCI_BIT     = 0;
  localparam int SLP_EN_BIT  = 13;
  localparam int SLP_TYP_LO  = 10;
  localparam int SLP_TYP_W   = 3;
  localparam int RST_GO_BIT  = 2;
  localparam int NUM_SLOTS   = 3;

  localparam logic [SLP_TYP_W-1:0] SLP_TYP_OFF = 3'd5;
  localparam logic [CTL_W-1:0] ZERO_MASK  = 16'hC003;
  localparam logic [CTL_W-1:0] STORE_MASK =
    ~(ZERO_MASK | (16'h0001 << SLP_EN_BIT));

  typedef struct packed {
    logic rstWr;
    logic rstRd;
    logic ctlWr;
    logic ctlRd;
    logic cmdWr;
    logic cmdRd;
    logic sizeErr;
  } busStrb_t;

endpackage

// File: rtl/slp_rst_decode.sv
module slp_rst_decode
  import slp_rst_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RST_ADDR = 16'h0CF9,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h0404,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h00B2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  output busStrb_t          strb
);

  localparam logic [ADDR_W-1:0] SLOT_ADDR [NUM_SLOTS] = '{RST_ADDR, CTL_ADDR, CMD_ADDR};
  localparam accSize_e          SLOT_SIZE [NUM_SLOTS] = '{SZ_BYTE, SZ_HALF, SZ_BYTE};

  logic [NUM_SLOTS-1:0] slotHit;
  logic [NUM_SLOTS-1:0] slotSizeOk;
  logic                 anyAcc;
  logic                 rdOnly;

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
    assign slotHit[gi]    = (busAddr == SLOT_ADDR[gi]);
    assign slotSizeOk[gi] = (accSize_e'(busSize) == SLOT_SIZE[gi]);
  end

  assign anyAcc = busRd | busWr;
  assign rdOnly = busRd & ~busWr;

  always_comb begin
    strb         = '0;
    strb.rstWr   = busWr  & slotHit[0] & slotSizeOk[0];
    strb.rstRd   = rdOnly & slotHit[0] & slotSizeOk[0];
    strb.ctlWr   = busWr  & slotHit[1] & slotSizeOk[1];
    strb.ctlRd   = rdOnly & slotHit[1] & slotSizeOk[1];
    strb.cmdWr   = busWr  & slotHit[2] & slotSizeOk[2];
    strb.cmdRd   = rdOnly & slotHit[2] & slotSizeOk[2];
    strb.sizeErr = anyAcc & |(slotHit & ~slotSizeOk);
  end

endmodule

// File: rtl/slp_rst_regs.sv
module slp_rst_regs
  import slp_rst_pkg::*;
#(
  parameter logic [7:0] CMD_ENABLE  = 8'hA0,
  parameter logic [7:0] CMD_DISABLE = 8'hA1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  busStrb_t         strb,
  input  logic [CTL_W-1:0] busWdata,
  output logic [CTL_W-1:0] busRdata,
  output logic             busErr,
  output logic             rstReq,
  output logic             pwrOffReq,
  output logic             sciEn,
  output logic             pwrBtnArm
);

  logic [7:0]       rstReg;
  logic [CTL_W-1:0] ctlBody;
  logic             sciQ;
  logic             armQ;
  logic             rstPulse;
  logic             offPulse;
  logic [CTL_W-1:0] rdataQ;
  logic             errQ;

  logic             rstRise;
  logic             offHit;
  logic [CTL_W-1:0] ctlView;
  logic [CTL_W-1:0] rdNext;

  assign rstRise = strb.rstWr & busWdata[RST_GO_BIT] & ~rstReg[RST_GO_BIT];
  assign offHit  = strb.ctlWr & busWdata[SLP_EN_BIT] &
                   (busWdata[SLP_TYP_LO +: SLP_TYP_W] == SLP_TYP_OFF);
  assign ctlView = ctlBody | (CTL_W'(sciQ) << SCI_BIT);

  always_comb begin
    rdNext = '0;
    if (strb.rstRd) rdNext = {{(CTL_W-8){1'b0}}, rstReg};
    else if (strb.ctlRd) rdNext = ctlView;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstReg   <= '0;
      ctlBody  <= '0;
      sciQ     <= 1'b0;
      armQ     <= 1'b0;
      rstPulse <= 1'b0;
      offPulse <= 1'b0;
      rdataQ   <= '0;
      errQ     <= 1'b0;
    end else begin
      rstPulse <= rstRise;
      offPulse <= offHit;
      rdataQ   <= rdNext;
      errQ     <= strb.sizeErr;
      if (strb.rstWr) rstReg <= busWdata[7:0];
      if (strb.ctlWr) ctlBody <= busWdata & STORE_MASK;
      if (strb.cmdWr) begin
        if (busWdata[7:0] == CMD_ENABLE) begin
          sciQ <= 1'b1;
          armQ <= 1'b1;
        end else if (busWdata[7:0] == CMD_DISABLE) begin
          sciQ <= 1'b0;
          armQ <= 1'b0;
        end
      end
    end
  end

  assign busRdata  = rdataQ;
  assign busErr    = errQ;
  assign rstReq    = rstPulse;
  assign pwrOffReq = offPulse;
  assign sciEn     = sciQ;
  assign pwrBtnArm = armQ;

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rstPulse |=> !rstPulse); // R2
  AST_RST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rstPulse |-> (rstReg[RST_GO_BIT] && !$past(rstReg[RST_GO_BIT]))); // R2
  AST_SCI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ctlWr |=> (sciQ == $past(sciQ))); // R5
  AST_OFF_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    offPulse |-> (ctlBody[SLP_TYP_LO +: SLP_TYP_W] == SLP_TYP_OFF)); // R6
  AST_SLPEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ctlBody[SLP_EN_BIT]); // R4
  AST_ARM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (armQ != $past(armQ)) |-> $past(strb.cmdWr)); // R7
  AST_ERR_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.sizeErr |=> ($stable(rstReg) && $stable(ctlBody) && $stable(sciQ))); // R8

endmodule

// File: rtl/slp_rst_ctl.sv
module slp_rst_ctl
  import slp_rst_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] RST_ADDR    = 16'h0CF9,
  parameter logic [ADDR_W-1:0] CTL_ADDR    = 16'h0404,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 16'h00B2,
  parameter logic [7:0]        CMD_ENABLE  = 8'hA0,
  parameter logic [7:0]        CMD_DISABLE = 8'hA1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  output logic              busErr,
  output logic              rstReq,
  output logic              pwrOffReq,
  output logic              sciEn,
  output logic              pwrBtnArm
);

  busStrb_t strb;

  slp_rst_decode #(
    .ADDR_W  (ADDR_W),
    .RST_ADDR(RST_ADDR),
    .CTL_ADDR(CTL_ADDR),
    .CMD_ADDR(CMD_ADDR)
  ) i_decode (
    .busAddr(busAddr),
    .busRd  (busRd),
    .busWr  (busWr),
    .busSize(busSize),
    .strb   (strb)
  );

  slp_rst_regs #(
    .CMD_ENABLE (CMD_ENABLE),
    .CMD_DISABLE(CMD_DISABLE)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .busErr   (busErr),
    .rstReq   (rstReq),
    .pwrOffReq(pwrOffReq),
    .sciEn    (sciEn),
    .pwrBtnArm(pwrBtnArm)
  );

endmodule

// File: tb/test_slp_rst_ctl.sv
module test_slp_rst_ctl;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_RST = 16'h0CF9;
  localparam logic [15:0] A_CTL = 16'h1004;
  localparam logic [15:0] A_CMD = 16'h00B2;
  localparam logic [7:0]  C_EN  = 8'hF0;
  localparam logic [7:0]  C_DIS = 8'h0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] busAddr = '0;
  logic busRd = 1'b0;
  logic busWr = 1'b0;
  logic [1:0] busSize = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic busErr, rstReq, pwrOffReq, sciEn, pwrBtnArm;

  int nCmp = 0;
  int nBad = 0;
  bit running = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slp_rst_ctl #(
    .ADDR_W(16), .RST_ADDR(A_RST), .CTL_ADDR(A_CTL), .CMD_ADDR(A_CMD),
    .CMD_ENABLE(C_EN), .CMD_DISABLE(C_DIS)
  ) i_slp_rst_ctl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .rstReq(rstReq), .pwrOffReq(pwrOffReq), .sciEn(sciEn), .pwrBtnArm(pwrBtnArm)
  );

  // behavioural reference model
  int mRst, mCtl, mSci, mArm;
  int eRd, eErr, eRstP, eOffP;

  always @(posedge clk) begin
    if (!rst_n) begin
      mRst = 0; mCtl = 0; mSci = 0; mArm = 0;
      eRd = 0; eErr = 0; eRstP = 0; eOffP = 0;
    end else begin
      int wd;
      wd = int'(busWdata);
      eRd = 0; eErr = 0; eRstP = 0; eOffP = 0;
      if (busWr || busRd) begin
        if (busAddr == A_RST || busAddr == A_CMD) begin
          if (busSize != 2'd0) eErr = 1;
        end else if (busAddr == A_CTL) begin
          if (busSize != 2'd1) eErr = 1;
        end
      end
      if (!eErr && busWr) begin
        if (busAddr == A_RST) begin
          if (((wd / 4) % 2 == 1) && ((mRst / 4) % 2 == 0)) eRstP = 1;
          mRst = wd % 256;
        end else if (busAddr == A_CTL) begin
          if (((wd / 8192) % 2 == 1) && ((wd / 1024) % 8 == 5)) eOffP = 1;
          mCtl = 0;
          for (int b = 2; b <= 12; b++) if (busWdata[b]) mCtl += (1 << b);
        end else if (busAddr == A_CMD) begin
          if (wd % 256 == int'(C_EN)) begin mSci = 1; mArm = 1; end
          else if (wd % 256 == int'(C_DIS)) begin mSci = 0; mArm = 0; end
        end
      end else if (!eErr && busRd) begin
        if (busAddr == A_RST) eRd = mRst;
        else if (busAddr == A_CTL) eRd = mCtl + mSci;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      check("R10", "busRdata", int'(busRdata), eRd);
      check("R8", "busErr", int'(busErr), eErr);
      check("R2", "rstReq", int'(rstReq), eRstP);
      check("R6", "pwrOffReq", int'(pwrOffReq), eOffP);
      check("R5", "sciEn", int'(sciEn), mSci);
      check("R7", "pwrBtnArm", int'(pwrBtnArm), mArm);
    end
  end

  task automatic acc(input bit wr, input logic [15:0] a, input logic [1:0] sz,
                     input logic [15:0] d, output int rdv, output int pr, output int po);
    @(negedge clk);
    busWr = wr; busRd = !wr; busAddr = a; busSize = sz; busWdata = d;
    @(negedge clk);
    rdv = int'(busRdata); pr = int'(rstReq); po = int'(pwrOffReq);
    busWr = 1'b0; busRd = 1'b0; busWdata = '0;
  endtask

  initial begin
    int v, p, o;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "reset busRdata", int'(busRdata), 0);
    check("R9", "reset outputs", int'({busErr, rstReq, pwrOffReq, sciEn, pwrBtnArm}), 0);
    rst_n = 1'b1;
    running = 1'b1;
    acc(0, A_CTL, 2'd1, 0, v, p, o);
    check("R9", "ctl after reset", v, 0);

    // R1 / R2 / R3
    acc(1, A_RST, 2'd0, 16'h00A4, v, p, o); check("R2", "rise pulse", p, 1);
    acc(0, A_RST, 2'd0, 0, v, p, o);        check("R1", "readback", v, 'hA4);
    acc(1, A_RST, 2'd0, 16'h0004, v, p, o); check("R2", "no pulse when held", p, 0);
    acc(1, A_RST, 2'd0, 16'h0000, v, p, o);
    acc(1, A_RST, 2'd0, 16'h0006, v, p, o); check("R3", "hard reset pulse", p, 1);
    acc(1, A_RST, 2'd0, 16'h0002, v, p, o); check("R3", "hard no bit2", p, 0);
    acc(1, A_RST, 2'd0, 16'h0004, v, p, o); check("R3", "soft reset pulse", p, 1);

    // R4 / R5 / R6
    acc(1, A_CTL, 2'd1, 16'hFFFF, v, p, o); check("R6", "typ 7 no off", o, 0);
    acc(0, A_CTL, 2'd1, 0, v, p, o);        check("R4", "masked store", v, 'h1FFC);
    acc(1, A_CMD, 2'd0, {8'h00, C_EN}, v, p, o);
    acc(1, A_CTL, 2'd1, 16'h0000, v, p, o);
    acc(0, A_CTL, 2'd1, 0, v, p, o);        check("R5", "sci kept", v, 1);
    acc(1, A_CTL, 2'd1, 16'h1400, v, p, o); check("R6", "typ 5 no enable", o, 0);
    acc(1, A_CTL, 2'd1, 16'h3000, v, p, o); check("R6", "typ 4 enable", o, 0);
    acc(1, A_CTL, 2'd1, 16'h3400, v, p, o); check("R6", "typ 5 enable off", o, 1);
    acc(0, A_CTL, 2'd1, 0, v, p, o);        check("R4", "slp_en reads 0", v, 'h1401);

    // R7
    acc(1, A_CMD, 2'd0, 16'h00A0, v, p, o);
    acc(1, A_CMD, 2'd0, 16'h0055, v, p, o);
    check("R7", "other code ignored", int'(sciEn), 1);
    acc(0, A_CMD, 2'd0, 0, v, p, o);        check("R7", "cmd reads 0", v, 0);
    acc(1, A_CMD, 2'd0, {8'h00, C_DIS}, v, p, o);
    check("R7", "disable", int'({sciEn, pwrBtnArm}), 0);
    acc(1, A_CMD, 2'd0, 16'h00A1, v, p, o);
    check("R7", "other code ignored 2", int'(pwrBtnArm), 0);

    // R8
    acc(1, A_CTL, 2'd0, 16'h0C00, v, p, o);
    acc(1, A_RST, 2'd1, 16'h0000, v, p, o);
    acc(0, A_RST, 2'd2, 0, v, p, o);        check("R8", "bad size rdata", v, 0);
    acc(1, A_CMD, 2'd3, {8'h00, C_EN}, v, p, o);
    check("R8", "bad cmd ignored", int'(sciEn), 0);
    acc(0, A_CTL, 2'd1, 0, v, p, o);        check("R8", "ctl unchanged", v, 'h1400);
    acc(0, A_RST, 2'd0, 0, v, p, o);        check("R8", "rst unchanged", v, 'h04);

    // R10: unmapped
    acc(0, 16'h0123, 2'd1, 0, v, p, o);     check("R10", "unmapped read", v, 0);
    acc(1, 16'h0123, 2'd0, 16'hFFFF, v, p, o);

    repeat (4) @(negedge clk);
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nCmp++; nBad++;
    $display("FAIL R9 watchdog actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule